// File: doc/BRIEF.md
# Peripheral input pin-select matrix

This block connects external I/O pins to the inputs of on-chip digital peripherals. Every peripheral input owns a 6-bit selection register. The register names one port and one pin within that port. The level of the named pin is routed to that peripheral input through purely combinational logic. Several peripheral inputs may name the same pin, and each of them then receives that pin's level. Synchronization of the routed signals belongs to the peripherals.

Each pin has an analog-enable bit. While that bit is set, the pin's digital input buffer is off. The pin then reads as 0 both on the port read-back output and on every peripheral input that selects it. Each selection register accepts only the two ports allowed for its input, and any other write is dropped. Inputs marked as bidirectional also produce an agreement flag. The flag tells whether the matching output routing names the same pin.

Software reaches the registers over a simple bus. Register `i` sits at address `i`. Read data is registered.

Top module: `pinsel_matrix`

## Requirements
- R1: After a synchronous reset, each selection register holds its own default code. For inputs 0 to 7 these are 001000, 000100, 010000, 010100, 010101, 010011, 010100 and 000000.
- R2: A selection code has the port in bits [5:3] (0 = A, 1 = B, 2 = C) and the pin number in bits [2:0]. Peripheral input `i` follows `pin_lvl[port*8+pin]`.
- R3: A bus write to address `i` whose port field is legal loads `bus_wdata[5:0]` into register `i` at that clock edge. Routing follows the new code right after the edge.
- R4: A write is ignored if its port field is 3 or higher, or lies outside the input's allowed pair. The allowed pairs are: inputs 0 and 1 take A/B, inputs 2 and 7 take A/C, inputs 3 to 6 take B/C.
- R5: Any number of peripheral inputs may select the same pin at once, and all of them follow its level.
- R6: `port_rd[j]` equals `pin_lvl[j]` while `pin_analog[j]` is 0 and reads 0 while it is 1, whatever the selections are.
- R7: A peripheral input whose selected pin has its analog-enable bit set reads 0.
- R8: `bus_rdata` presents, one clock edge after the address, the addressed register's code in bits [5:0] with bits [7:6] zero. Addresses 8 to 15 read 0, and writes to them change no register.
- R9: For bidirectional inputs (5 and 6), `bidir_agree[i]` is 1 exactly when register `i` equals `out_route[i*6 +: 6]`. For the other inputs it is always 1.
- R10: A change on `pin_lvl` or `pin_analog` reaches `periph_in` and `port_rd` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data; bits [5:0] carry the code |
| bus_rdata | output | 8 | Registered read data |
| pin_lvl | input | 24 | Raw pin levels, index port*8+pin |
| pin_analog | input | 24 | Analog-enable bit per pin |
| port_rd | output | 24 | Port read-back levels |
| out_route | input | 48 | Output-routing code paired with each input, 6 bits per input |
| periph_in | output | 8 | Routed level for each peripheral input |
| bidir_agree | output | 8 | Agreement flag for each input |

## Verification
`periph_in`, `port_rd` and `bidir_agree` are combinational. They are due in the same cycle as any pin, analog or out-route change, and in the cycle just after the clock edge that takes a register write. `bus_rdata` is due one edge after its address is presented. The bench drives inputs at the falling edge and compares every output against its behavioural model 2 ns later, so all four results are checked once per cycle. A directed case also changes a pin halfway through the low phase and checks the routed value before the next rising edge.

// File: rtl/pinsel_pkg.sv
`timescale 1ns/1ps
package pinsel_pkg;
  localparam int CODE_W = 6;
  localparam int PORT_W = 3;
  localparam int PIN_W  = 3;

  function automatic logic [PORT_W-1:0] code_port(input logic [CODE_W-1:0] c);
    return c[CODE_W-1:PIN_W];
  endfunction

  function automatic logic [PIN_W-1:0] code_pin(input logic [CODE_W-1:0] c);
    return c[PIN_W-1:0];
  endfunction
endpackage

// File: rtl/pinsel_buffer.sv
`timescale 1ns/1ps
module pinsel_buffer #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] pin_analog,
  output logic [NUM_PINS-1:0] pin_dig
);
  // Digital input buffer: disabled pins present logic 0
  always_comb begin
    for (int j = 0; j < NUM_PINS; j++) begin
      pin_dig[j] = pin_lvl[j] & ~pin_analog[j];
    end
  end

  // R6
  portrd_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_dig & pin_analog) == '0);
endmodule

// File: rtl/pinsel_reg.sv
`timescale 1ns/1ps
module pinsel_reg
  import pinsel_pkg::*;
#(
  parameter int                NUM_PORTS = 3,
  parameter logic [CODE_W-1:0] RST_CODE  = '0,
  parameter logic [PORT_W-1:0] ALLOW_LO  = '0,
  parameter logic [PORT_W-1:0] ALLOW_HI  = 3'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code
);
  logic [PORT_W-1:0] wr_port;
  logic              wr_legal;

  always_comb begin
    wr_port  = code_port(wr_code);
    wr_legal = (int'(wr_port) < NUM_PORTS) &&
               ((wr_port == ALLOW_LO) || (wr_port == ALLOW_HI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= RST_CODE;
    end else if (wr_hit && wr_legal) begin
      code <= wr_code;
    end
  end

  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_legal) |=> code == $past(wr_code));
  // R4
  wr_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wr_legal) |=> $stable(code));
  // R4
  port_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(code_port(code)) < NUM_PORTS);
endmodule

// File: rtl/pinsel_mux.sv
`timescale 1ns/1ps
module pinsel_mux
  import pinsel_pkg::*;
#(
  parameter int NUM_PORTS     = 3,
  parameter int PINS_PER_PORT = 8,
  localparam int NUM_PINS     = NUM_PORTS * PINS_PER_PORT,
  localparam int IDX_W        = $clog2(NUM_PINS)
) (
  input  logic [CODE_W-1:0]   code,
  input  logic [NUM_PINS-1:0] pin_dig,
  output logic [IDX_W-1:0]    pin_idx,
  output logic                lvl
);
  int flat;

  always_comb begin
    flat    = int'(code_port(code)) * PINS_PER_PORT + int'(code_pin(code));
    pin_idx = IDX_W'(flat);
    lvl     = 1'b0;
    if (flat < NUM_PINS) begin
      lvl = pin_dig[pin_idx];
    end
  end
endmodule

// File: rtl/pinsel_matrix.sv
`timescale 1ns/1ps
module pinsel_matrix
  import pinsel_pkg::*;
#(
  parameter int NUM_PORTS     = 3,
  parameter int PINS_PER_PORT = 8,
  parameter int NUM_SEL       = 8,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter logic [NUM_SEL*CODE_W-1:0] RST_CODES =
    {6'o00, 6'o24, 6'o23, 6'o25, 6'o24, 6'o20, 6'o04, 6'o10},
  parameter logic [NUM_SEL*2*PORT_W-1:0] ALLOW_PAIRS =
    {6'o20, 6'o21, 6'o21, 6'o21, 6'o21, 6'o20, 6'o10, 6'o10},
  parameter logic [NUM_SEL-1:0] BIDIR_MASK = 8'b0110_0000,
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT,
  localparam int SEL_W    = $clog2(NUM_SEL),
  localparam int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_PINS-1:0]       pin_lvl,
  input  logic [NUM_PINS-1:0]       pin_analog,
  output logic [NUM_PINS-1:0]       port_rd,
  input  logic [NUM_SEL*CODE_W-1:0] out_route,
  output logic [NUM_SEL-1:0]        periph_in,
  output logic [NUM_SEL-1:0]        bidir_agree
);
  logic [NUM_PINS-1:0] pin_dig;
  logic [CODE_W-1:0]   codes [NUM_SEL];
  logic [IDX_W-1:0]    sel_idx [NUM_SEL];
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CODE_W];

  pinsel_buffer #(.NUM_PINS(NUM_PINS)) u_buffer (
    .clk        (clk),
    .rst        (rst),
    .pin_lvl    (pin_lvl),
    .pin_analog (pin_analog),
    .pin_dig    (pin_dig)
  );

  assign port_rd = pin_dig;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    logic wr_hit;
    assign wr_hit = bus_we && (bus_addr == ADDR_W'(i));

    pinsel_reg #(
      .NUM_PORTS (NUM_PORTS),
      .RST_CODE  (RST_CODES[i*CODE_W +: CODE_W]),
      .ALLOW_LO  (ALLOW_PAIRS[i*2*PORT_W +: PORT_W]),
      .ALLOW_HI  (ALLOW_PAIRS[i*2*PORT_W+PORT_W +: PORT_W])
    ) u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_hit),
      .wr_code (bus_wdata[CODE_W-1:0]),
      .code    (codes[i])
    );

    pinsel_mux #(
      .NUM_PORTS     (NUM_PORTS),
      .PINS_PER_PORT (PINS_PER_PORT)
    ) u_mux (
      .code    (codes[i]),
      .pin_dig (pin_dig),
      .pin_idx (sel_idx[i]),
      .lvl     (periph_in[i])
    );

    if (BIDIR_MASK[i]) begin : g_bidir
      assign bidir_agree[i] = (codes[i] == out_route[i*CODE_W +: CODE_W]);
    end else begin : g_uni
      assign bidir_agree[i] = 1'b1;
    end

    // R7
    route_gate_chk: assert property (@(posedge clk) disable iff (rst)
      pin_analog[sel_idx[i]] |-> !periph_in[i]);
    // R2
    route_pass_chk: assert property (@(posedge clk) disable iff (rst)
      !pin_analog[sel_idx[i]] |-> periph_in[i] == pin_lvl[sel_idx[i]]);
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (int'(bus_addr) < NUM_SEL) begin
      bus_rdata <= DATA_W'(codes[bus_addr[SEL_W-1:0]]);
    end else begin
      bus_rdata <= '0;
    end
  end

  // R8
  rd_upper_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:CODE_W] == '0);
  // R8
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(bus_addr) >= NUM_SEL) |=> bus_rdata == '0);
endmodule

// File: tb/test_pinsel_matrix.sv
`timescale 1ns/1ps
module test_pinsel_matrix;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_lvl = '0;
  logic [23:0] pin_analog = '0;
  logic [23:0] port_rd;
  logic [47:0] out_route = '0;
  logic [7:0]  periph_in;
  logic [7:0]  bidir_agree;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit live = 0;

  int rst_tab [8] = '{8, 4, 16, 20, 21, 19, 20, 0};
  int allow_a [8] = '{0, 0, 0, 1, 1, 1, 1, 0};
  int allow_b [8] = '{1, 1, 2, 2, 2, 2, 2, 2};
  int is_bidir[8] = '{0, 0, 0, 0, 0, 1, 1, 0};
  int ref_code[8];
  int exp_rd = 0;

  always #5 clk = ~clk;

  pinsel_matrix i_pinsel_matrix (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lvl(pin_lvl),
    .pin_analog(pin_analog), .port_rd(port_rd), .out_route(out_route),
    .periph_in(periph_in), .bidir_agree(bidir_agree)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_periph(int i);
    int idx;
    idx = (ref_code[i] >> 3) * 8 + (ref_code[i] & 7);
    return (pin_lvl[idx] & ~pin_analog[idx]) ? 1 : 0;
  endfunction

  function automatic int exp_periph_vec();
    int v = 0;
    for (int i = 0; i < 8; i++) v |= exp_periph(i) << i;
    return v;
  endfunction

  function automatic int exp_bidir_vec();
    int v = 0;
    for (int i = 0; i < 8; i++) begin
      if (is_bidir[i] == 0 || ref_code[i] == int'(out_route[i*6 +: 6])) v |= 1 << i;
    end
    return v;
  endfunction

  // Behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) ref_code[i] = rst_tab[i];
      exp_rd = 0;
    end else begin
      int a, p;
      a = int'(bus_addr);
      exp_rd = (a < 8) ? ref_code[a] : 0;
      p = int'(bus_wdata[5:3]);
      if (bus_we && a < 8 && p < 3 && (p == allow_a[a] || p == allow_b[a]))
        ref_code[a] = int'(bus_wdata[5:0]);
    end
    live = 1;
  end

  // Compare every cycle, 2 ns after the falling edge
  always begin
    @(negedge clk);
    #2;
    if (live && !done) begin
      check("R2 R7 periph_in", int'(periph_in), exp_periph_vec());
      check("R6 port_rd", int'(port_rd), int'(pin_lvl & ~pin_analog));
      check("R9 bidir_agree", int'(bidir_agree), exp_bidir_vec());
      check("R8 bus_rdata", int'(bus_rdata), exp_rd);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    #3;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    bus_addr = 4'(a);
    @(negedge clk);
    #3;
    v = int'(bus_rdata);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset codes
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check("R1 reset code", v, rst_tab[i]);
    end

    // R2 default routing: input 0 -> B0 (bit 8), input 1 -> A4 (bit 4)
    @(negedge clk); pin_lvl = 24'h000110; #3;
    check("R2 input0 B0", int'(periph_in[0]), 1);
    check("R2 input1 A4", int'(periph_in[1]), 1);

    // R3 legal write: input 1 -> B3 (bit 11)
    wr(1, 8'o13);
    pin_lvl = 24'h000800; #1;
    check("R3 input1 B3", int'(periph_in[1]), 1);
    rd(1, v);
    check("R3 readback", v, 8'o13);

    // R4 illegal: input 2 allowed A/C, port B rejected; port 3 rejected on input 0
    wr(2, 8'o12);
    rd(2, v);
    check("R4 disallowed port", v, 8'o20);
    wr(0, 8'o31);
    rd(0, v);
    check("R4 port code 3", v, 8'o10);

    // R5 shared pin: inputs 3 and 4 -> C6 (bit 22)
    wr(3, 8'o26);
    wr(4, 8'o26);
    pin_lvl = 24'h400000; #1;
    check("R5 input3 C6", int'(periph_in[3]), 1);
    check("R5 input4 C6", int'(periph_in[4]), 1);

    // R7 analog mode masks the pin
    pin_analog = 24'h400000; #1;
    check("R7 input3 gated", int'(periph_in[3]), 0);
    check("R7 input4 gated", int'(periph_in[4]), 0);
    check("R6 port_rd gated", int'(port_rd[22]), 0);
    pin_analog = '0;

    // R8 unmapped address reads 0; upper data bits dropped
    rd(12, v);
    check("R8 unmapped read", v, 0);
    wr(12, 8'o00);
    wr(0, 8'hC8);
    rd(0, v);
    check("R8 upper bits zero", v, 8'h08);

    // R9 bidirectional agreement on input 5 (code 010011)
    @(negedge clk); out_route[5*6 +: 6] = 6'o23; #3;
    check("R9 agree", int'(bidir_agree[5]), 1);
    out_route[5*6 +: 6] = 6'o24; out_route[0 +: 6] = 6'o77; #1;
    check("R9 disagree", int'(bidir_agree[5]), 0);
    check("R9 non-bidir", int'(bidir_agree[0]), 1);

    // R10 combinational path mid-cycle
    @(negedge clk); #3;
    pin_lvl = 24'h000100; #1;
    check("R10 same-cycle route", int'(periph_in[0]), 1);
    check("R10 same-cycle port", int'(port_rd[8]), 1);

    // Mixed random traffic against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      bus_addr   = 4'($urandom_range(0, 15));
      bus_we     = 1'($urandom_range(0, 1));
      bus_wdata  = {2'($urandom), 3'($urandom_range(0, 3)), 3'($urandom)};
      pin_lvl    = 24'($urandom);
      pin_analog = 24'($urandom) & 24'($urandom);
      out_route  = {16'($urandom), 32'($urandom)};
    end
    @(negedge clk); bus_we = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule